// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns two quadrature phase signals from an incremental position sensor into a signed motion count held in a 16-bit wrapping register. A 3-bit mode input selects which phase transitions produce a count: one transition per electrical cycle on either phase, both transitions of one phase, or all four transitions. Two further modes produce no count at all. A cascade mode ignores the phases and follows two external active-low step requests, so that a wider counter can be built from several of these blocks.

Each phase is captured into a register on the falling clock edge and copied into a second register on the rising edge. A count step is decided on the rising edge by comparing those two samples. If both phases differ between the two samples, the transition is treated as invalid and nothing is counted. The counter wraps at its ends and marks each wrap with a one-clock low strobe: one strobe for wrapping upward and another for wrapping downward. A host can overwrite either byte of the counter through a simple byte write port. A write takes priority over a count step in the same clock.

Top module: `qdec_counter`

## Requirements
- R1: While `rstN` is low, `count` is 0, `carryN` and `borrowN` are 1, and both phase sample registers hold 0. If both phases are already high when reset is released, that first sample counts as an invalid transition and `count` stays 0.
- R2: With `phaseA` leading `phaseB`, steps increment `count`. With `phaseA` lagging, steps decrement it. The forward sequence of {phaseA,phaseB} is 00, 10, 11, 01. Up and down steps never occur in the same clock.
- R3: In mode 3'b001 exactly one count is made per electrical cycle: on the rising edge of `phaseA` when moving forward, and on its falling edge when moving backward.
- R4: In mode 3'b010 exactly one count is made per electrical cycle: on the rising edge of `phaseB` when moving forward, and on its falling edge when moving backward.
- R5: Mode 3'b011 counts both edges of `phaseA`, which gives two counts per cycle. Mode 3'b100 counts both edges of `phaseB`, which also gives two counts per cycle.
- R6: Mode 3'b101 counts every edge of both phases, which gives four counts per cycle.
- R7: Modes 3'b110 and 3'b111 produce no count, whatever the phases do.
- R8: A sample in which both phases changed since the previous sample produces no count.
- R9: Mode 3'b000 ignores the phases. In that mode, each clock in which `upReqN` alone is low adds one, and each clock in which `downReqN` alone is low subtracts one. If both are low, nothing is counted. In every other mode both requests are ignored.
- R10: `count` wraps modulo 2^16. `carryN` is low for exactly the one clock that follows a step from 16'hFFFF to 16'h0000. `borrowN` is low for exactly the one clock that follows a step from 16'h0000 to 16'hFFFF. The two strobes are never low together.
- R11: When `wrEn` is high, `wrData` replaces byte `wrSel` of `count` at the rising edge: 0 selects bits 7:0 and 1 selects bits 15:8. The other byte is kept, and any step in that same clock is dropped.
- R12: A phase change that is stable before a falling clock edge shows in `count` after the rising edge that follows it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Phases are captured on its falling edge; state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseA | input | 1 | First quadrature phase |
| phaseB | input | 1 | Second quadrature phase |
| mode | input | 3 | Selects the edges that count (see R3 to R9) |
| upReqN | input | 1 | Active-low step-up request, used in mode 3'b000 |
| downReqN | input | 1 | Active-low step-down request, used in mode 3'b000 |
| wrEn | input | 1 | Byte write enable |
| wrSel | input | 1 | Byte select for writes, 0 for the low byte |
| wrData | input | 8 | Byte value to write |
| count | output | 16 | Current counter value |
| carryN | output | 1 | Low for one clock after an upward wrap |
| borrowN | output | 1 | Low for one clock after a downward wrap |

## Verification
Full forward and backward electrical cycles are driven in every mode. The number of counts per cycle separates the one-edge, two-edge and four-edge modes. The sign of the count shows whether direction is decoded correctly, and for the single-edge modes whether the correct edge is used in each direction. Simultaneous flips of both phases, the two non-counting modes, and cascade requests in both matching and non-matching modes check that no count appears where none belongs. Writes that place the counter at 16'hFFFF and 16'h0000, followed by a single step, exercise both wraps and their strobes. A long random walk over modes, directions, invalid flips and byte writes is then checked step by step against a position model kept in the bench.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [2:0] {
    MODE_CASCADE = 3'd0,
    MODE_X1_A    = 3'd1,
    MODE_X1_B    = 3'd2,
    MODE_X2_A    = 3'd3,
    MODE_X2_B    = 3'd4,
    MODE_X4      = 3'd5,
    MODE_IDLE_A  = 3'd6,
    MODE_IDLE_B  = 3'd7
  } modeT;

  typedef struct packed {
    logic up;
    logic down;
  } stepT;
endpackage

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseA,
  input  logic       phaseB,
  input  logic [2:0] mode,
  input  logic       upReqN,
  input  logic       downReqN,
  output stepT       step
);
  // bit 1 = phase A, bit 0 = phase B
  logic [1:0] capFall;
  logic [1:0] capRise;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) capFall <= 2'b00;
    else       capFall <= {phaseA, phaseB};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capRise <= 2'b00;
    else       capRise <= capFall;
  end

  logic aChg, bChg, legalMove, fwd, take, hit;
  modeT modeSel;

  always_comb begin
    modeSel   = modeT'(mode);
    aChg      = capFall[1] ^ capRise[1];
    bChg      = capFall[0] ^ capRise[0];
    legalMove = aChg ^ bChg;
    // A moving: forward when new A differs from B; B moving: forward when equal
    fwd       = aChg ? (capFall[1] ^ capFall[0]) : ~(capFall[1] ^ capFall[0]);
    unique case (modeSel)
      MODE_X1_A: take = aChg & (fwd ? capFall[1] : ~capFall[1]);
      MODE_X1_B: take = bChg & (fwd ? capFall[0] : ~capFall[0]);
      MODE_X2_A: take = aChg;
      MODE_X2_B: take = bChg;
      MODE_X4:   take = 1'b1;
      default:   take = 1'b0;
    endcase
    hit = legalMove & take;
    if (modeSel == MODE_CASCADE) begin
      step.up   = ~upReqN & downReqN;
      step.down = ~downReqN & upReqN;
    end else begin
      step.up   = hit & fwd;
      step.down = hit & ~fwd;
    end
  end
endmodule

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NUM_BYTES = CNT_W / BYTE_W,
  localparam int SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepT              step,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              carryN,
  output logic              borrowN
);
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] nxtCount;
  logic             wrapUp, wrapDn;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gLane
    assign loadVal[g*BYTE_W +: BYTE_W] =
      (wrSel == SEL_W'(g)) ? wrData : count[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    nxtCount = count;
    wrapUp   = 1'b0;
    wrapDn   = 1'b0;
    if (wrEn) begin
      nxtCount = loadVal;
    end else if (step.up) begin
      nxtCount = count + 1'b1;
      wrapUp   = &count;
    end else if (step.down) begin
      nxtCount = count - 1'b1;
      wrapDn   = ~|count;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      carryN  <= 1'b1;
      borrowN <= 1'b1;
    end else begin
      count   <= nxtCount;
      carryN  <= ~wrapUp;
      borrowN <= ~wrapDn;
    end
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic [2:0]        mode,
  input  logic              upReqN,
  input  logic              downReqN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              carryN,
  output logic              borrowN
);
  stepT step;

  qdec_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .phaseA   (phaseA),
    .phaseB   (phaseB),
    .mode     (mode),
    .upReqN   (upReqN),
    .downReqN (downReqN),
    .step     (step)
  );

  qdec_datapath #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .step    (step),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .count   (count),
    .carryN  (carryN),
    .borrowN (borrowN)
  );
endmodule

// File: rtl/qdec_counter_chk.sv
module qdec_counter_chk
  import qdec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        mode,
  input logic              wrEn,
  input logic              wrSel,
  input logic [BYTE_W-1:0] wrData,
  input logic [CNT_W-1:0]  count,
  input logic              carryN,
  input logic              borrowN,
  input stepT              step
);
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !carryN |-> (count == '0 && $past(count) == '1)) else $error("carry strobe without wrap"); // R10
  AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !borrowN |-> (count == '1 && $past(count) == '0)) else $error("borrow strobe without wrap"); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!carryN && !borrowN)) else $error("both strobes low"); // R10
  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(step)) else $error("up and down together"); // R2
  AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && mode[2] && mode[1]) |=> $stable(count)) else $error("count moved in idle mode"); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (count[BYTE_W-1:0] == $past(wrData))) else $error("low byte write lost"); // R11
endmodule

bind qdec_counter qdec_counter_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .mode    (mode),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .count   (count),
  .carryN  (carryN),
  .borrowN (borrowN),
  .step    (step)
);

// File: tb/qdec_counter_test.sv
module qdec_counter_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseA = 1'b1, phaseB = 1'b1;
  logic [2:0]  mode = 3'd5;
  logic        upReqN = 1'b1, downReqN = 1'b1;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [15:0] count;
  logic        carryN, borrowN;

  int checks = 0, fails = 0;
  logic [15:0] expCnt = 16'h0000;
  logic [1:0]  prevAB = 2'b00;
  bit          finished = 0;

  qdec_counter uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic int gpos(logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] posAB(int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  // expected step from the position model: +1, -1 or 0
  function automatic int qstep(logic [1:0] pv, logic [1:0] nx, logic [2:0] m);
    int d, e;
    bit fwd, take;
    d = (gpos(nx) - gpos(pv)) & 3;
    if (d == 0 || d == 2) return 0;
    fwd = (d == 1);
    e = fwd ? gpos(pv) : gpos(nx);
    case (m)
      3'd1: take = (e == 0);
      3'd2: take = (e == 1);
      3'd3: take = (e % 2 == 0);
      3'd4: take = (e % 2 == 1);
      3'd5: take = 1;
      default: take = 0;
    endcase
    if (!take) return 0;
    return fwd ? 1 : -1;
  endfunction

  task automatic expectStep(string req, int d);
    logic expC, expB;
    expC = !(d == 1 && expCnt == 16'hFFFF);
    expB = !(d == -1 && expCnt == 16'h0000);
    expCnt = expCnt + 16'(d);
    @(posedge clk); #2;
    check(req, "count", count, expCnt);
    check(req, "carryN", {15'd0, carryN}, {15'd0, expC});
    check(req, "borrowN", {15'd0, borrowN}, {15'd0, expB});
  endtask

  task automatic applyQ(string req, logic [1:0] ab, logic [2:0] m);
    int d;
    @(posedge clk); #2;
    {phaseA, phaseB} = ab;
    mode = m;
    d = qstep(prevAB, ab, m);
    prevAB = ab;
    expectStep(req, d);
  endtask

  task automatic cycleDir(string req, logic [2:0] m, bit fwd);
    for (int i = 1; i <= 4; i++)
      applyQ(req, posAB(gpos(prevAB) + (fwd ? 1 : 3)), m);
  endtask

  task automatic casc(string req, logic u, logic dn, logic [2:0] m);
    int d;
    @(posedge clk); #2;
    mode = m; upReqN = u; downReqN = dn;
    d = 0;
    if (m == 3'd0) d = (!u && dn) ? 1 : ((!dn && u) ? -1 : 0);
    expectStep(req, d);
    upReqN = 1'b1; downReqN = 1'b1;
  endtask

  task automatic writeByte(string req, logic sel, logic [7:0] v);
    @(posedge clk); #2;
    wrEn = 1'b1; wrSel = sel; wrData = v;
    if (sel) expCnt[15:8] = v; else expCnt[7:0] = v;
    @(posedge clk); #2;
    wrEn = 1'b0;
    check(req, "count after write", count, expCnt);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check("R1", "reset count", count, 16'h0000);
    check("R1", "reset carryN", {15'd0, carryN}, 16'd1);
    check("R1", "reset borrowN", {15'd0, borrowN}, 16'd1);
    rstN = 1'b1;
    prevAB = 2'b00;                 // samplers cleared by reset
    applyQ("R1", 2'b11, 3'd5);      // first sample 11 vs cleared 00: invalid

    cycleDir("R6", 3'd5, 1);
    check("R6", "four per cycle", expCnt, 16'd4);
    cycleDir("R2", 3'd5, 0);
    cycleDir("R3", 3'd1, 1);
    check("R3", "one per cycle fwd", count, 16'd1);
    cycleDir("R3", 3'd1, 0);
    cycleDir("R4", 3'd2, 1);
    cycleDir("R4", 3'd2, 0);
    cycleDir("R5", 3'd3, 1);
    check("R5", "two per cycle A", count, 16'd2);
    cycleDir("R5", 3'd4, 0);
    check("R5", "two per cycle B", count, 16'd0);
    cycleDir("R7", 3'd6, 1);
    cycleDir("R7", 3'd7, 0);
    check("R7", "idle modes", count, 16'd0);

    // R8: both phases flip at once
    applyQ("R8", posAB(gpos(prevAB) + 2), 3'd5);
    applyQ("R8", posAB(gpos(prevAB) + 2), 3'd5);

    // R9: cascade requests
    casc("R9", 1'b0, 1'b1, 3'd0);
    casc("R9", 1'b0, 1'b1, 3'd0);
    casc("R9", 1'b1, 1'b0, 3'd0);
    casc("R9", 1'b0, 1'b0, 3'd0);
    casc("R9", 1'b0, 1'b1, 3'd5);
    applyQ("R9", posAB(gpos(prevAB) + 1), 3'd0);  // phases ignored in cascade

    // R10: both wraps
    writeByte("R11", 1'b0, 8'hFF);
    writeByte("R11", 1'b1, 8'hFF);
    applyQ("R10", posAB(gpos(prevAB) + 1), 3'd5);
    check("R10", "wrap up", count, 16'h0000);
    applyQ("R10", posAB(gpos(prevAB) + 3), 3'd5);
    check("R10", "wrap down", count, 16'hFFFF);
    applyQ("R10", prevAB, 3'd5);   // strobes released

    // R11: high byte only, then write beats a step
    writeByte("R11", 1'b1, 8'h5A);
    check("R11", "low byte kept", count, 16'h5AFF);
    @(posedge clk); #2;
    wrEn = 1'b1; wrSel = 1'b0; wrData = 8'h3C;
    {phaseA, phaseB} = posAB(gpos(prevAB) + 1); mode = 3'd5;
    prevAB = {phaseA, phaseB};
    expCnt = 16'h5A3C;
    @(posedge clk); #2;
    wrEn = 1'b0;
    check("R11", "write wins over step", count, expCnt);

    // R12: latency
    @(posedge clk); #2;
    {phaseA, phaseB} = posAB(gpos(prevAB) + 1);
    prevAB = {phaseA, phaseB};
    @(negedge clk); #1;
    check("R12", "before rising edge", count, expCnt);
    expCnt = expCnt + 16'd1;
    @(posedge clk); #2;
    check("R12", "after rising edge", count, expCnt);

    // random walk
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [2:0] m;
      r = int'($urandom % 16);
      m = 3'($urandom_range(1, 7));
      if (r == 0) writeByte("R11", 1'($urandom % 2), 8'($urandom));
      else if (r == 1) applyQ("R8", posAB(gpos(prevAB) + 2), m);
      else if (r < 9) applyQ("R2", posAB(gpos(prevAB) + 1), m);
      else if (r < 15) applyQ("R2", posAB(gpos(prevAB) + 3), m);
      else casc("R9", 1'($urandom % 2), 1'($urandom % 2), 3'($urandom % 2));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule